// File: doc/BRIEF.md
# Deterministic Stochastic Bitstream Pair Generator

This block turns two unsigned operands into two unipolar stochastic bitstreams. It uses counters and comparators only, with no random source. A stream that encodes k/N is high while its index counter is below k. The two index counters are sequenced so that, over one full run, every bit position of the first stream meets every bit position of the second stream exactly once. ANDing the two streams downstream therefore gives a ones count equal to the exact product of the operands, with no sampling error.

Three pairing schemes can be selected at start time. In the coprime scheme the two streams have periods N and N−1. In the rotation scheme the second stream is read with an offset that grows by one after each pass of the first stream. In the clock-division scheme the second stream steps once per pass of the first stream. A start pulse latches the operands and the scheme. The streams then run for the whole pairing period, and a one-cycle end flag marks the final bit. The counters then park until the next start.

Top module: `sc_pair_gen`

## Requirements
- R1: While reset is held and after it is released with no start, both streams and the end flag are low.
- R2: Stream A is high in the cycles whose position within each 16-cycle pass is below operand A, so every pass carries exactly A ones.
- R3: Mode code 0 (coprime) runs 240 cycles. Stream B repeats every 15 cycles with B ones per repetition, and the AND of the two streams holds A*B ones.
- R4: Mode code 2 (clock division) runs 256 cycles. Stream B holds one value for a whole 16-cycle pass, high in pass j exactly when j < B, and the AND holds A*B ones.
- R5: Mode code 1 (rotation) runs 256 cycles. Every 16-cycle pass of stream B carries B ones, and the AND holds A*B ones.
- R6: The end flag is high for exactly one cycle, together with the last bit of the run. In the cycle after it, both streams are low.
- R7: A start is rejected, with no bits and no end flag, if mode code is 3, if either operand exceeds 16, or if operand B equals 16 in coprime mode.
- R8: A start that arrives while a run is in progress is ignored, and the run keeps its original operands and length.
- R9: The first bit of a run appears in the cycle that follows the clock edge at which the start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with the current operands and mode |
| mode | input | 2 | Pairing scheme: 0 coprime, 1 rotation, 2 clock division |
| op_a | input | W+1 | Operand A, range 0..2^W |
| op_b | input | W+1 | Operand B, range 0..2^W (0..2^W−1 in coprime mode) |
| stream_a | output | 1 | Bitstream for operand A |
| stream_b | output | 1 | Bitstream for operand B |
| done | output | 1 | High on the last bit of the run |

## Verification
The bench aims at the operand extremes 0 and 16 in each scheme. There, a stream that mishandles full scale would lose one bit per pass, and the AND count would miss A*B. It compares run lengths of 240 and 256 cycles, where an off-by-one in the total counter would move the end flag or leak an extra bit. It also checks per-pass patterns of stream B: a clock-division counter that steps every cycle, or a rotation offset that never advances, keeps the total count plausible but breaks the pass structure. Finally, it drives rejected and mid-run starts, where a design that accepts them would emit bits or restart the run.

// File: rtl/sc_pair_pkg.sv
package sc_pair_pkg;
   typedef enum logic [1:0] {
      PAIR_COPRIME = 2'd0,
      PAIR_ROTATE  = 2'd1,
      PAIR_CLKDIV  = 2'd2,
      PAIR_RSVD    = 2'd3
   } pair_mode_e;
endpackage

// File: rtl/sc_modcnt.sv
module sc_modcnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [CW:0]   limit,
   output logic [CW-1:0] cnt,
   output logic          wrap
);
   assign wrap = ({1'b0, cnt} == (limit - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= wrap ? '0 : cnt + 1'b1;
   end

   AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ({1'b0, cnt} < limit)); // R3
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wrap && !clr) |=> (cnt == $past(cnt) + 1'b1)); // R2
endmodule

// File: rtl/sc_thresh.sv
module sc_thresh #(
   parameter int W = 4
) (
   input  logic         act,
   input  logic [W-1:0] idx,
   input  logic [W:0]   level,
   output logic         bit_o
);
   assign bit_o = act && ({1'b0, idx} < level);
endmodule

// File: rtl/sc_pair_gen.sv
module sc_pair_gen
   import sc_pair_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   mode,
   input  logic [W:0]   op_a,
   input  logic [W:0]   op_b,
   output logic         stream_a,
   output logic         stream_b,
   output logic         done
);
   localparam int N  = 1 << W;
   localparam int TW = 2 * W;
   localparam logic [TW-1:0] LAST_CP = TW'(N * (N - 1) - 1);
   localparam logic [TW-1:0] LAST_SQ = TW'(N * N - 1);

   if (W < 2 || W > 8) begin : g_bad_width
      $error("sc_pair_gen: W must lie in 2..8");
   end

   pair_mode_e    mode_q;
   logic          run;
   logic [W:0]    a_q, b_q;
   logic [TW-1:0] tot;
   logic          ok, accept, last;
   logic [W-1:0]  cnt_a, cnt_b;
   logic          wrap_a, wrap_b;
   logic          en_b;
   logic [W:0]    lim_b;

   assign ok = (pair_mode_e'(mode) != PAIR_RSVD) &&
               (op_a <= (W+1)'(N)) && (op_b <= (W+1)'(N)) &&
               !((pair_mode_e'(mode) == PAIR_COPRIME) && (op_b == (W+1)'(N)));
   assign accept = start && !run && ok;
   assign last   = run && (tot == ((mode_q == PAIR_COPRIME) ? LAST_CP : LAST_SQ));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         mode_q <= PAIR_COPRIME;
         a_q    <= '0;
         b_q    <= '0;
         tot    <= '0;
      end else if (accept) begin
         run    <= 1'b1;
         mode_q <= pair_mode_e'(mode);
         a_q    <= op_a;
         b_q    <= op_b;
         tot    <= '0;
      end else if (last) begin
         run    <= 1'b0;
      end else if (run) begin
         tot    <= tot + 1'b1;
      end
   end

   assign en_b  = run && !last && ((mode_q == PAIR_COPRIME) || wrap_a);
   assign lim_b = (mode_q == PAIR_COPRIME) ? (W+1)'(N - 1) : (W+1)'(N);

   sc_modcnt #(.CW(W)) u_cnt_a (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(run && !last),
      .limit((W+1)'(N)), .cnt(cnt_a), .wrap(wrap_a));

   sc_modcnt #(.CW(W)) u_cnt_b (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(en_b),
      .limit(lim_b), .cnt(cnt_b), .wrap(wrap_b));

   logic [W-1:0] idx_l   [2];
   logic [W:0]   level_l [2];
   logic [1:0]   bits_l;

   assign idx_l[0]   = cnt_a;
   assign idx_l[1]   = (mode_q == PAIR_ROTATE) ? W'(cnt_a + cnt_b) : cnt_b;
   assign level_l[0] = a_q;
   assign level_l[1] = b_q;

   for (genvar g = 0; g < 2; g++) begin : g_lane
      sc_thresh #(.W(W)) u_cmp (
         .act(run), .idx(idx_l[g]), .level(level_l[g]), .bit_o(bits_l[g]));
   end

   assign stream_a = bits_l[0];
   assign stream_b = bits_l[1];
   assign done     = last;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!stream_a && !stream_b)); // R6
   AST_CLKDIV_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode_q == PAIR_CLKDIV && !wrap_a) |=> $stable(cnt_b)); // R4
   AST_COPRIME_B_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode_q == PAIR_COPRIME && wrap_b && !last) |=> (cnt_b == '0)); // R3
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start && !last) |=> ($stable(a_q) && $stable(b_q) && $stable(mode_q))); // R8
   AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !run && !ok) |=> !run); // R7
endmodule

// File: tb/sim_sc_pair_gen.sv
module sim_sc_pair_gen;
   localparam int W = 4;
   localparam int N = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [W:0]   op_a = '0;
   logic [W:0]   op_b = '0;
   logic         stream_a, stream_b, done;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   sc_pair_gen #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .op_a(op_a), .op_b(op_b),
      .stream_a(stream_a), .stream_b(stream_b), .done(done));

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
         report();
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int run_len(input int md);
      return (md == 0) ? N * (N - 1) : N * N;
   endfunction

   task automatic run_pair(input int md, input int a, input int b, input bit mid);
      int len, ones_a, ones_b, ones_and, bad_a, bad_b, done_early, done_last, seg_b;
      len = run_len(md);
      ones_a = 0; ones_b = 0; ones_and = 0; bad_a = 0; bad_b = 0;
      done_early = 0; done_last = 0; seg_b = 0;
      @(negedge clk);
      start = 1'b1; mode = 2'(md); op_a = (W+1)'(a); op_b = (W+1)'(b);
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < len; i++) begin
         ones_a   += int'(stream_a);
         ones_b   += int'(stream_b);
         ones_and += int'(stream_a & stream_b);
         if (stream_a != ((i % N) < a)) bad_a++;
         if (md == 2 && stream_b != ((i / N) < b)) bad_b++;
         if (md == 1) begin
            seg_b += int'(stream_b);
            if ((i % N) == N - 1) begin
               if (seg_b != b) bad_b++;
               seg_b = 0;
            end
         end
         if (md == 0 && i < N - 1) seg_b += int'(stream_b);
         if (i == len - 1) done_last = int'(done);
         else if (done) done_early++;
         if (mid && i == 100) begin
            start = 1'b1; op_a = (W+1)'((a + 5) % N); op_b = (W+1)'((b + 3) % (N - 1));
         end
         if (mid && i == 101) start = 1'b0;
         @(negedge clk);
      end
      chk($sformatf("R2 stream A pattern m%0d a%0d", md, a), bad_a, 0);
      chk("R2 stream A ones total", ones_a, a * (len / N));
      case (md)
         0: begin
            chk("R3 AND ones coprime", ones_and, a * b);
            chk("R3 B ones over first 15 cycles", seg_b, b);
            chk("R3 B ones total", ones_b, b * N);
         end
         1: begin
            chk("R5 AND ones rotation", ones_and, a * b);
            chk("R5 B passes with wrong ones count", bad_b, 0);
         end
         default: begin
            chk("R4 AND ones clock division", ones_and, a * b);
            chk("R4 B pass-hold pattern errors", bad_b, 0);
         end
      endcase
      chk("R6 done on last bit", done_last, 1);
      chk("R6 done before last bit", done_early, 0);
      chk("R6 quiet after done", int'(stream_a | stream_b | done), 0);
      if (mid) chk("R8 mid-run start ignored, AND ones", ones_and, a * b);
   endtask

   task automatic reject(input int md, input int a, input int b);
      int seen;
      seen = 0;
      @(negedge clk);
      start = 1'b1; mode = 2'(md); op_a = (W+1)'(a); op_b = (W+1)'(b);
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 300; i++) begin
         seen += int'(stream_a | stream_b | done);
         @(negedge clk);
      end
      chk($sformatf("R7 rejected start m%0d a%0d b%0d produced activity", md, a, b), seen, 0);
   endtask

   initial begin
      int quiet;
      void'($urandom(32'd1337));
      quiet = 0;
      repeat (3) begin
         @(negedge clk);
         quiet += int'(stream_a | stream_b | done);
      end
      chk("R1 outputs low in reset", quiet, 0);
      rst_n = 1'b1;
      quiet = 0;
      repeat (5) begin
         @(negedge clk);
         quiet += int'(stream_a | stream_b | done);
      end
      chk("R1 outputs low idle after reset", quiet, 0);

      // R9: operand 16 gives a high first bit right after the start edge
      @(negedge clk);
      start = 1'b1; mode = 2'd2; op_a = (W+1)'(N); op_b = (W+1)'(N);
      chk("R9 no bit in start cycle", int'(stream_a), 0);
      @(negedge clk);
      start = 1'b0;
      chk("R9 first bit follows start", int'(stream_a & stream_b), 1);
      while (!done) @(negedge clk);
      @(negedge clk);

      // R3 R4 R5 directed corners
      run_pair(0, N, N - 1, 1'b0);
      run_pair(0, 0, 7, 1'b0);
      run_pair(1, N, N, 1'b0);
      run_pair(1, 1, 1, 1'b0);
      run_pair(2, N, 0, 1'b0);
      run_pair(2, 9, N, 1'b0);
      run_pair(1, 6, 11, 1'b1);
      run_pair(0, 3, 4, 1'b1);

      // R7 rejection cases
      reject(0, 5, N);
      reject(3, 5, 5);
      reject(2, N + 1, 2);
      reject(1, 3, N + 3);

      // random runs across all three schemes
      for (int k = 0; k < 24; k++) begin
         int md, a, b;
         md = int'($urandom % 3);
         a  = int'($urandom % (N + 1));
         b  = (md == 0) ? int'($urandom % N) : int'($urandom % (N + 1));
         run_pair(md, a, b, ($urandom % 4) == 0);
      end
      report();
   end
endmodule